// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a 256-byte memory that answers as a target on a two-wire serial bus (SMBus/I2C style). It oversamples SCL and SDA with the system clock and detects START and STOP conditions. It shifts in the address byte and acknowledges only its own 7-bit address. It then serves the transaction that follows. An 8-bit pointer holds the current offset and serves sequential reads. A parallel port preloads or updates the array from the chip side.

A write-direction transaction that carries exactly one byte is a pointer load. That byte becomes the current offset when the transaction ends, either with STOP or with a repeated START. This one rule covers both the plain send-byte operation and the command phase of a combined read. When more bytes follow the first byte, the first byte is the start address and every later byte is stored in the array. Block transfers carry no byte-count field. Writes roll over from the top of the array to address 0x00.

Top module: `smbus_eeprom_target`

## Requirements
- R1: A pulse on `init_we` writes `init_data` into the array at `init_addr`. The bus later reads back that value at that address.
- R2: The target acknowledges the address `BASE_ADDR + dev_sel` (default 0x50 to 0x57) by pulling SDA low in the ninth clock. It leaves SDA released (NACK) for any other address.
- R3: A write-direction transaction with exactly one byte (send byte) loads that byte into the current offset. It stores nothing in the array.
- R4: A read-direction transaction returns the byte at the current offset, MSB first. After each byte the offset increments, and 0xFF rolls over to 0x00.
- R5: In a write-direction transaction, the first byte is a start address. Every later byte is payload, with no count byte, and is stored at successive addresses that roll over from 0xFF to 0x00. Each byte is acknowledged.
- R6: A multi-byte write leaves the current offset unchanged.
- R7: In a combined read, the command byte is followed by a repeated START and a read address. The command byte sets the offset before the first data byte. The target keeps sending bytes while the controller ACKs, and it releases SDA after the controller NACKs.
- R8: A quick command (write direction) is acknowledged. It changes neither the offset nor the array.
- R9: After reset the current offset is 0x00.
- R10: SDA is only ever pulled low (`sda_oe`=1) or released. `sda_oe` rises only while SCL is low and is 0 during reset.
- R11: A START or STOP seen while SCL is high aborts any transfer in progress and releases SDA. A data byte cut short by STOP is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 3 | Instance index added to `BASE_ADDR` |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| init_we | input | 1 | Parallel preload write strobe |
| init_addr | input | 8 | Preload address |
| init_data | input | 8 | Preload data |

## Verification
The bound checker checks on every cycle that `sda_oe` only turns on while the synchronised SCL is low (R10). It also checks that a START or STOP releases SDA on the next cycle (R11), and that array writes leave the offset alone (R6). Finally, it checks that the offset changes only on a byte load, where it steps by one (R4), or at the end of a transaction (R3). Only the bench's bus scenarios can show the address match and mismatch and the rollover of reads and writes across 0xFF. The same holds for the difference between send byte, quick command and multi-byte write, and for a truncated byte being dropped. Each of these is observed as acknowledge bits and as data read back over the bus.

// File: rtl/smbus_eeprom_target.sv
module smbus_eeprom_target #(
  parameter logic [6:0] BASE_ADDR = 7'h50,
  parameter int         AW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    dev_sel,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          init_we,
  input  logic [AW-1:0] init_addr,
  input  logic [7:0]    init_data
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  st_t           st;
  logic [2:0]    scl_p, sda_p;
  logic [3:0]    cnt;
  logic [7:0]    sr, tx;
  logic [AW-1:0] offset, wptr, cmd;
  logic [1:0]    nb;
  logic          rw, ack_ok;
  logic [7:0]    mem [DEPTH];

  wire scl_s   = scl_p[1];
  wire scl_q   = scl_p[2];
  wire sda_s   = sda_p[1];
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_p[2] & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_p[2] & sda_s;

  wire       addr_hit  = sr[7:1] == BASE_ADDR + {4'b0000, dev_sel};
  wire       byte_done = fall && cnt == 4'd8;
  wire       mem_we    = byte_done && st == S_WR && nb != 2'd0;
  wire       ld        = fall && ((st == S_AACK && rw) || (st == S_RACK && ack_ok));
  wire [7:0] rd_byte   = mem[offset];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sr     <= '0;
      tx     <= '0;
      offset <= '0;
      wptr   <= '0;
      cmd    <= '0;
      nb     <= '0;
      rw     <= 1'b0;
      ack_ok <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_c || stop_c) begin
      if (!rw && nb == 2'd1) offset <= cmd;
      st     <= start_c ? S_ADDR : S_IDLE;
      cnt    <= '0;
      nb     <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (ld) begin
        tx     <= {rd_byte[6:0], 1'b0};
        sda_oe <= ~rd_byte[7];
        offset <= offset + 1'b1;
        cnt    <= 4'd1;
        st     <= S_RD;
      end
      unique case (st)
        S_ADDR: begin
          if (rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            if (addr_hit) begin
              rw     <= sr[0];
              sda_oe <= 1'b1;
              st     <= S_AACK;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_AACK: if (fall && !rw) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          st     <= S_WR;
        end
        S_WR: begin
          if (rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            sda_oe <= 1'b1;
            st     <= S_WACK;
            if (nb == 2'd0) begin
              cmd  <= sr;
              wptr <= sr;
              nb   <= 2'd1;
            end else begin
              wptr <= wptr + 1'b1;
              nb   <= 2'd2;
            end
          end
        end
        S_WACK: if (fall) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          st     <= S_WR;
        end
        S_RD: if (fall) begin
          if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
            st     <= S_RACK;
          end else begin
            sda_oe <= ~tx[7];
            tx     <= {tx[6:0], 1'b0};
            cnt    <= cnt + 4'd1;
          end
        end
        S_RACK: begin
          if (rise) ack_ok <= ~sda_s;
          else if (fall && !ack_ok) st <= S_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (init_we)     mem[init_addr] <= init_data;
    else if (mem_we) mem[wptr]      <= sr;
  end
endmodule

// File: rtl/smbus_eeprom_chk.sv
module smbus_eeprom_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          start_c,
  input logic          stop_c,
  input logic          ld,
  input logic          mem_we,
  input logic [AW-1:0] offset
);
  a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r11_release_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> !sda_oe);

  a_r6_write_keeps_offset: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> $stable(offset));

  a_r4_offset_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> offset == $past(offset) + 1'b1);

  a_r3_offset_change_src: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset) |-> $past(ld || start_c || stop_c));
endmodule

bind smbus_eeprom_target smbus_eeprom_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_s   (scl_s),
  .sda_oe  (sda_oe),
  .start_c (start_c),
  .stop_c  (stop_c),
  .ld      (ld),
  .mem_we  (mem_we),
  .offset  (offset)
);

// File: tb/smbus_eeprom_target_tb.sv
module smbus_eeprom_target_tb;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] dev_sel = 3'd0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       init_we = 1'b0;
  logic [7:0] init_addr = '0, init_data = '0;
  logic       sda_oe;
  wire        sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  smbus_eeprom_target u_dut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data)
  );

  logic [7:0] model [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_v;
  event       obs_ev;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  task automatic expect_v(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_v = v;
    -> obs_ev;
    @(negedge clk);
  endtask

  initial forever begin
    @(obs_ev);
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected item: actual %02h expected none", obs_v);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (obs_v !== e) begin
        n_bad++;
        $display("FAIL %s: actual %02h expected %02h", t, obs_v, e);
      end
    end
  end

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hold();
    scl_m = 1'b1; hold(); hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    b = sda_line; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic send8(input logic [7:0] v, input logic exp_ack, input string t);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    expect_v({7'd0, exp_ack}, t);
    observe({7'd0, a});
  endtask

  task automatic recv8(input logic [7:0] e, input logic nack, input string t);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(nack);
    expect_v(e, t);
    observe(v);
  endtask

  task automatic receive1(input logic [7:0] e, input string t);
    bus_start();
    send8({7'h50, 1'b1}, 1'b0, {t, " addr ack"});
    recv8(e, 1'b1, t);
    bus_stop();
  endtask

  task automatic send_byte(input logic [7:0] v, input string t);
    bus_start();
    send8({7'h50, 1'b0}, 1'b0, {t, " addr ack"});
    send8(v, 1'b0, {t, " byte ack"});
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    expect_v(8'h00, "R10 sda_oe in reset");
    observe({7'd0, sda_oe});
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) begin
      model[i] = 8'(i * 7 + 3);
      init_we = 1'b1; init_addr = 8'(i); init_data = model[i];
      @(negedge clk);
    end
    init_we = 1'b0;
    hold();

    receive1(model[8'h00], "R9 offset zero after reset");

    bus_start();
    send8({7'h51, 1'b0}, 1'b1, "R2 foreign address NACK");
    bus_stop();

    dev_sel = 3'd3;
    bus_start();
    send8({7'h53, 1'b1}, 1'b0, "R2 indexed address ACK");
    recv8(model[8'h01], 1'b1, "R4 read after index");
    bus_stop();
    dev_sel = 3'd0;

    send_byte(8'hFE, "R3 send byte");
    bus_start();
    send8({7'h50, 1'b1}, 1'b0, "R4 read addr");
    recv8(model[8'hFE], 1'b0, "R4 byte FE");
    recv8(model[8'hFF], 1'b0, "R4 byte FF");
    recv8(model[8'h00], 1'b1, "R4 rollover to 00");
    bus_stop();

    bus_start();
    send8({7'h50, 1'b0}, 1'b0, "R5 addr ack");
    send8(8'hFD, 1'b0, "R5 command ack");
    send8(8'h11, 1'b0, "R5 data ack");
    send8(8'h22, 1'b0, "R5 data ack");
    send8(8'h33, 1'b0, "R5 data ack");
    send8(8'h44, 1'b0, "R5 data ack");
    bus_stop();
    model[8'hFD] = 8'h11; model[8'hFE] = 8'h22;
    model[8'hFF] = 8'h33; model[8'h00] = 8'h44;

    receive1(model[8'h01], "R6 offset kept after write");

    bus_start();
    send8({7'h50, 1'b0}, 1'b0, "R7 addr ack");
    send8(8'hFD, 1'b0, "R7 command ack");
    bus_start();
    send8({7'h50, 1'b1}, 1'b0, "R7 read addr ack");
    recv8(8'h11, 1'b0, "R7/R5 byte FD");
    recv8(8'h22, 1'b0, "R7/R5 byte FE");
    recv8(8'h33, 1'b0, "R7/R5 byte FF");
    recv8(8'h44, 1'b1, "R7/R5 rolled byte 00");
    expect_v(8'h00, "R7 SDA released after NACK");
    observe({7'd0, sda_oe});
    bus_stop();
    receive1(model[8'h01], "R7 offset after sequential read");

    bus_start();
    send8({7'h50, 1'b0}, 1'b0, "R8 quick command ack");
    bus_stop();
    receive1(model[8'h02], "R8 quick command no effect");

    bus_start();
    send8({7'h50, 1'b0}, 1'b0, "R11 addr ack");
    send8(8'h40, 1'b0, "R11 command ack");
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    expect_v(8'h00, "R11 SDA released on STOP");
    observe({7'd0, sda_oe});
    receive1(model[8'h40], "R11 truncated byte dropped");
    receive1(model[8'h41], "R11 next location untouched");

    init_we = 1'b1; init_addr = 8'h80; init_data = 8'h5C;
    @(negedge clk);
    init_we = 1'b0;
    model[8'h80] = 8'h5C;
    send_byte(8'h80, "R1 pointer load");
    receive1(8'h5C, "R1 runtime preload read back");

    send_byte(8'h90, "R3 pointer only");
    receive1(model[8'h90], "R3 array not written by send byte");

    hold();
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule